// File: doc/BRIEF.md
# Indexed Load Address Generator

This block forms the bus address and the base-register update value for a 32-bit load whose offset comes from a register. The offset value first passes through a barrel shifter. The shift can be a logical left shift, a logical right shift, an arithmetic right shift, a rotate right, or a one-bit rotate through the carry flag. The shifted offset is then added to the base value or subtracted from it.

The block supports three indexing modes. Plain offset mode only forms an address. Pre-indexed mode uses the updated base as the address and also writes it back. Post-indexed mode reads at the unmodified base and writes the updated base back.

A narrow-encoding variant input limits the block to an add-only left shift of a few bit positions. Any other combination is flagged as illegal. Register aliasing between the destination and the base register in a writeback mode is also flagged as illegal.

The result is registered behind a valid/ready handshake that holds one entry. A new operand set is accepted when the output register is empty, or when its content is taken in the same cycle.

Top module: `idx_load_agen`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high. An operand set accepted on a clock edge appears on the outputs with `out_valid` high right after that edge. After reset, `out_valid`, `out_wb_en` and `out_illegal` are low.
- R2: While `out_valid` is high and `out_ready` is low, all outputs keep their values.
- R3: `add_sel`=1 adds the shifted offset to `in_base`, and `add_sel`=0 subtracts it. Both wrap modulo 2^32.
- R4: `shift_kind`=0 shifts left by `shift_amt`, from 0 to 31. `shift_kind`=1 shifts right logically by `shift_amt`, and an amount code of 0 means 32, which gives zero.
- R5: `shift_kind`=2 shifts right arithmetically by `shift_amt`, and an amount code of 0 means 32, which gives 32 copies of bit 31.
- R6: `shift_kind`=3 rotates right by `shift_amt`, from 1 to 31. An amount code of 0 instead shifts right by one and puts `in_carry` into bit 31.
- R7: With `idx_mode`=0 (offset), `out_addr` is the base plus or minus the offset, and `out_wb_en` is 0.
- R8: With `idx_mode`=1 (pre-indexed), `out_addr` and `out_wb_data` both equal the base plus or minus the offset, and `out_wb_en` is 1 unless the operation is illegal.
- R9: With `idx_mode`=2 (post-indexed), `out_addr` equals `in_base`, `out_wb_data` is the base plus or minus the offset, and `out_wb_en` is 1 unless the operation is illegal.
- R10: With `narrow_isa`=1, only `add_sel`=1 with `shift_kind`=0 and `shift_amt` from 0 to 3 is legal. Anything else sets `out_illegal`.
- R11: `out_illegal` is set when `idx_mode` is 1 or 2 and `dst_reg` equals `base_reg`, or when `idx_mode`=3. `idx_mode`=3 forms its address as in offset mode. An illegal result always has `out_wb_en`=0, while `out_addr` and `out_wb_data` still carry the computed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set |
| in_base | input | 32 | Base register value |
| in_offset | input | 32 | Offset register value |
| in_carry | input | 1 | Carry flag, used by rotate-through-carry |
| shift_kind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| shift_amt | input | 5 | Shift amount code |
| add_sel | input | 1 | 1 add offset, 0 subtract offset |
| idx_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 reserved |
| narrow_isa | input | 1 | Reduced-encoding variant |
| dst_reg | input | 4 | Destination register number |
| base_reg | input | 4 | Base register number |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Bus address |
| out_wb_data | output | 32 | Value to write back to the base register |
| out_wb_en | output | 1 | Write-back strobe |
| out_illegal | output | 1 | Illegal combination flag |

## Verification
Directed operands are used for each shift kind at the edges of its range. These are amount 0 and 31 for left shifts, code 0 (meaning 32) for the right shifts, and rotate-through-carry with each carry value. Together they separate a shifter that treats the zero code as a plain zero shift from one that expands it correctly.

Each indexing mode is run with the same base and offset. This shows whether the address and the writeback value are taken from the right source.

Narrow-variant cases straddle the largest legal left shift and also try subtraction. Aliasing cases are repeated in every mode, which separates the writeback-only aliasing rule from a global one.

A long stretch of random operands then runs with random stalls on both sides. It exposes ordering and hold errors in the handshake.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    IX_OFFSET = 2'd0,
    IX_PRE    = 2'd1,
    IX_POST   = 2'd2,
    IX_RSVD   = 2'd3
  } idx_e;
endpackage

// File: rtl/agen_shifter.sv
module agen_shifter
  import agen_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  val,
  input  logic [SHW-1:0] amt,
  input  shift_e         kind,
  input  logic           cin,
  output logic [DW-1:0]  res
);
  // A zero amount code selects the full-width form for right shifts
  // and the one-bit rotate through carry for the rotate kind.
  function automatic logic [DW-1:0] barrel(
    input logic [DW-1:0]  v,
    input logic [SHW-1:0] n,
    input shift_e         k,
    input logic           c
  );
    logic [2*DW-1:0] twin;
    logic [DW-1:0]   r;
    twin = {v, v} >> n;
    unique case (k)
      SH_LSL: r = v << n;
      SH_LSR: r = (n == '0) ? '0 : (v >> n);
      SH_ASR: r = (n == '0) ? {DW{v[DW-1]}} : DW'($signed(v) >>> n);
      default: r = (n == '0) ? {c, v[DW-1:1]} : twin[DW-1:0];
    endcase
    return r;
  endfunction

  assign res = barrel(val, amt, kind, cin);
endmodule

// File: rtl/agen_legal.sv
module agen_legal
  import agen_pkg::*;
#(
  parameter int SHW        = 5,
  parameter int RW         = 4,
  parameter int NARROW_MAX = 3
) (
  input  logic           narrow,
  input  logic           add_sel,
  input  shift_e         kind,
  input  logic [SHW-1:0] amt,
  input  idx_e           mode,
  input  logic [RW-1:0]  dst,
  input  logic [RW-1:0]  basereg,
  output logic           ill_narrow,
  output logic           ill_alias,
  output logic           ill_mode,
  output logic           illegal
);
  logic writes_base;

  assign writes_base = (mode == IX_PRE) || (mode == IX_POST);
  assign ill_narrow  = narrow && (!add_sel || (kind != SH_LSL) || (int'(amt) > NARROW_MAX));
  assign ill_alias   = writes_base && (dst == basereg);
  assign ill_mode    = (mode == IX_RSVD);
  assign illegal     = ill_narrow || ill_alias || ill_mode;
endmodule

// File: rtl/agen_index.sv
module agen_index
  import agen_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] off,
  input  logic          add_sel,
  input  idx_e          mode,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] addr,
  output logic          wants_wb
);
  function automatic logic [DW-1:0] combine(
    input logic [DW-1:0] b,
    input logic [DW-1:0] o,
    input logic          up
  );
    return up ? (b + o) : (b - o);
  endfunction

  assign sum      = combine(base, off, add_sel);
  assign addr     = (mode == IX_POST) ? base : sum;
  assign wants_wb = (mode == IX_PRE) || (mode == IX_POST);
endmodule

// File: rtl/idx_load_agen.sv
module idx_load_agen
  import agen_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RW         = 4,
  parameter int NARROW_MAX = 3,
  localparam int SHW       = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_base,
  input  logic [DW-1:0]  in_offset,
  input  logic           in_carry,
  input  logic [1:0]     shift_kind,
  input  logic [SHW-1:0] shift_amt,
  input  logic           add_sel,
  input  logic [1:0]     idx_mode,
  input  logic           narrow_isa,
  input  logic [RW-1:0]  dst_reg,
  input  logic [RW-1:0]  base_reg,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_addr,
  output logic [DW-1:0]  out_wb_data,
  output logic           out_wb_en,
  output logic           out_illegal
);
  shift_e kind;
  idx_e   mode;
  assign kind = shift_e'(shift_kind);
  assign mode = idx_e'(idx_mode);

  logic [DW-1:0] shifted, sum, addr_nxt;
  logic          wants_wb, ill_narrow, ill_alias, ill_mode, illegal_nxt;

  // Events brought out for the checker.
  logic capture;
  logic narrow_sub;
  idx_e q_mode;
  logic [DW-1:0] q_base;

  agen_shifter #(.DW(DW), .SHW(SHW)) u_shift (
    .val(in_offset), .amt(shift_amt), .kind(kind), .cin(in_carry), .res(shifted)
  );

  agen_index #(.DW(DW)) u_index (
    .base(in_base), .off(shifted), .add_sel(add_sel), .mode(mode),
    .sum(sum), .addr(addr_nxt), .wants_wb(wants_wb)
  );

  agen_legal #(.SHW(SHW), .RW(RW), .NARROW_MAX(NARROW_MAX)) u_legal (
    .narrow(narrow_isa), .add_sel(add_sel), .kind(kind), .amt(shift_amt),
    .mode(mode), .dst(dst_reg), .basereg(base_reg),
    .ill_narrow(ill_narrow), .ill_alias(ill_alias), .ill_mode(ill_mode),
    .illegal(illegal_nxt)
  );

  assign in_ready   = !out_valid || out_ready;
  assign capture    = in_valid && in_ready;
  assign narrow_sub = narrow_isa && !add_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_wb_data <= '0;
      out_wb_en   <= 1'b0;
      out_illegal <= 1'b0;
      q_mode      <= IX_OFFSET;
      q_base      <= '0;
    end else if (capture) begin
      out_valid   <= 1'b1;
      out_addr    <= addr_nxt;
      out_wb_data <= sum;
      out_wb_en   <= wants_wb && !illegal_nxt;
      out_illegal <= illegal_nxt;
      q_mode      <= mode;
      q_base      <= in_base;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/agen_checker.sv
module agen_checker
  import agen_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_addr,
  input logic [DW-1:0] out_wb_data,
  input logic          out_wb_en,
  input logic          out_illegal,
  input logic          capture,
  input logic          narrow_sub,
  input idx_e          q_mode,
  input logic [DW-1:0] q_base
);
  // R1
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> out_valid);

  // R1
  empty_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_wb_data) && $stable(out_wb_en) && $stable(out_illegal)));

  // R7
  offset_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == IX_OFFSET) |-> !out_wb_en);

  // R8
  pre_same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == IX_PRE) |-> (out_addr == out_wb_data));

  // R9
  post_base_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == IX_POST) |-> (out_addr == q_base));

  // R10
  narrow_sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && narrow_sub) |=> out_illegal);

  // R11
  illegal_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> !out_wb_en);
endmodule

bind idx_load_agen agen_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_wb_data(out_wb_data),
  .out_wb_en(out_wb_en), .out_illegal(out_illegal), .capture(capture),
  .narrow_sub(narrow_sub), .q_mode(q_mode), .q_base(q_base)
);

// File: tb/tb_idx_load_agen.sv
module tb_idx_load_agen;
  typedef struct {
    logic [31:0] base, off;
    logic        cin;
    int          kind, amt;
    logic        add;
    int          mode;
    logic        narrow;
    int          dst, br;
    string       tag;
  } stim_t;

  typedef struct {
    logic [31:0] addr, wb;
    logic        wben, ill;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_carry = 0, add_sel = 0, narrow_isa = 0, out_ready = 0;
  logic [31:0] in_base = 0, in_offset = 0;
  logic [1:0] shift_kind = 0, idx_mode = 0;
  logic [4:0] shift_amt = 0;
  logic [3:0] dst_reg = 0, base_reg = 0;
  logic in_ready, out_valid, out_wb_en, out_illegal;
  logic [31:0] out_addr, out_wb_data;

  int tests = 0, fails = 0;
  bit done = 0;
  stim_t stims[$];
  exp_t  expq[$];

  always #10 clk = ~clk;

  idx_load_agen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_offset(in_offset), .in_carry(in_carry),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .add_sel(add_sel),
    .idx_mode(idx_mode), .narrow_isa(narrow_isa), .dst_reg(dst_reg),
    .base_reg(base_reg), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_wb_data(out_wb_data), .out_wb_en(out_wb_en),
    .out_illegal(out_illegal)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(stim_t s);
    exp_t e;
    longint m = 64'hFFFF_FFFF;
    longint b = longint'(s.base), o = longint'(s.off), sh, sum, sv;
    int n = s.amt;
    case (s.kind)
      0: sh = (o << n) & m;
      1: sh = o >> ((n == 0) ? 32 : n);
      2: begin sv = longint'($signed(s.off)); sh = (sv >>> ((n == 0) ? 32 : n)) & m; end
      default: sh = (n == 0) ? ((s.cin ? 64'h8000_0000 : 64'h0) | (o >> 1))
                             : (((o << 32) | o) >> n) & m;
    endcase
    sum = s.add ? ((b + sh) & m) : ((b + 64'h1_0000_0000 - sh) & m);
    e.ill = (s.narrow && (!s.add || s.kind != 0 || n > 3)) || (s.mode == 3) ||
            ((s.mode == 1 || s.mode == 2) && s.dst == s.br);
    e.addr = (s.mode == 2) ? s.base : sum[31:0];
    e.wb   = sum[31:0];
    e.wben = !e.ill && (s.mode == 1 || s.mode == 2);
    e.tag  = s.tag;
    return e;
  endfunction

  task automatic add_stim(input logic [31:0] b, input logic [31:0] o, input logic c,
                          input int k, input int a, input logic ad, input int md,
                          input logic nw, input int d, input int r, input string t);
    stim_t s;
    s.base = b; s.off = o; s.cin = c; s.kind = k; s.amt = a; s.add = ad;
    s.mode = md; s.narrow = nw; s.dst = d; s.br = r; s.tag = t;
    stims.push_back(s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic held = 0;
    exp_t snap, e;
    int si = 0;

    // R3 add and subtract with wrap
    add_stim(32'd100, 32'd5, 0, 0, 0, 1, 0, 0, 1, 2, "R3");
    add_stim(32'd5, 32'd6, 0, 0, 0, 0, 0, 0, 1, 2, "R3");
    add_stim(32'hFFFF_FFFF, 32'd2, 0, 0, 0, 1, 0, 0, 1, 2, "R3");
    // R4 left and logical right edges
    add_stim(32'h1000, 32'h8000_0001, 0, 0, 31, 1, 0, 0, 1, 2, "R4");
    add_stim(32'h1000, 32'h8000_0001, 0, 1, 1, 1, 0, 0, 1, 2, "R4");
    add_stim(32'h1000, 32'hFFFF_FFFF, 0, 1, 0, 1, 0, 0, 1, 2, "R4");
    // R5 arithmetic right, code 0 means 32
    add_stim(32'h10, 32'h8000_0000, 0, 2, 0, 1, 0, 0, 1, 2, "R5");
    add_stim(32'h10, 32'h7FFF_FFFF, 0, 2, 0, 1, 0, 0, 1, 2, "R5");
    add_stim(32'h10, 32'hF000_0000, 0, 2, 31, 0, 0, 0, 1, 2, "R5");
    // R6 rotate and rotate through carry
    add_stim(32'h0, 32'h1234_5678, 0, 3, 8, 1, 0, 0, 1, 2, "R6");
    add_stim(32'h0, 32'h0000_0003, 1, 3, 0, 1, 0, 0, 1, 2, "R6");
    add_stim(32'h0, 32'h0000_0003, 0, 3, 0, 1, 0, 0, 1, 2, "R6");
    // R7 R8 R9 modes with the same operands
    add_stim(32'h2000, 32'h40, 0, 0, 2, 1, 0, 0, 3, 4, "R7");
    add_stim(32'h2000, 32'h40, 0, 0, 2, 1, 1, 0, 3, 4, "R8");
    add_stim(32'h2000, 32'h40, 0, 0, 2, 0, 2, 0, 3, 4, "R9");
    // R10 narrow variant
    add_stim(32'h300, 32'h1, 0, 0, 3, 1, 1, 1, 3, 4, "R10");
    add_stim(32'h300, 32'h1, 0, 0, 4, 1, 1, 1, 3, 4, "R10");
    add_stim(32'h300, 32'h1, 0, 0, 1, 0, 0, 1, 3, 4, "R10");
    add_stim(32'h300, 32'h1, 0, 1, 1, 1, 0, 1, 3, 4, "R10");
    // R11 aliasing and reserved mode
    add_stim(32'h500, 32'h8, 0, 0, 0, 1, 0, 0, 5, 5, "R11");
    add_stim(32'h500, 32'h8, 0, 0, 0, 1, 1, 0, 5, 5, "R11");
    add_stim(32'h500, 32'h8, 0, 0, 0, 1, 2, 0, 5, 5, "R11");
    add_stim(32'h500, 32'h8, 0, 0, 0, 0, 3, 0, 5, 6, "R11");
    for (int i = 0; i < 400; i++)
      add_stim($urandom, $urandom, 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 31),
               1'($urandom), $urandom_range(0, 3), ($urandom_range(0, 3) == 0),
               $urandom_range(0, 3), $urandom_range(0, 3), "R3");

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset out_valid", out_valid, 0);
    check("R1", "reset wb_en", out_wb_en, 0);
    check("R1", "reset illegal", out_illegal, 0);
    rst_n = 1;

    while (si < stims.size() || expq.size() != 0) begin
      @(negedge clk);
      if (held) begin
        // R2 hold while stalled
        check("R2", "held addr", out_addr, snap.addr);
        check("R2", "held wb_data", out_wb_data, snap.wb);
        check("R2", "held valid", out_valid, 1);
        held = 0;
      end
      // R1 result present exactly while one is owed
      check("R1", "out_valid", out_valid, expq.size() != 0);

      out_ready = ($urandom_range(0, 3) != 0);
      if (si < stims.size()) begin
        in_base = stims[si].base; in_offset = stims[si].off; in_carry = stims[si].cin;
        shift_kind = 2'(stims[si].kind); shift_amt = 5'(stims[si].amt);
        add_sel = stims[si].add; idx_mode = 2'(stims[si].mode);
        narrow_isa = stims[si].narrow; dst_reg = 4'(stims[si].dst);
        base_reg = 4'(stims[si].br);
        in_valid = ($urandom_range(0, 4) != 0);
      end else in_valid = 0;
      #1;
      check("R1", "in_ready", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready && expq.size() != 0) begin
        e = expq.pop_front();
        check(e.tag, "addr", out_addr, e.addr);
        check(e.tag, "wb_data", out_wb_data, e.wb);
        check(e.tag, "wb_en", out_wb_en, e.wben);
        check(e.tag, "illegal", out_illegal, e.ill);
      end else if (out_valid) begin
        held = 1;
        snap.addr = out_addr; snap.wb = out_wb_data;
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(stims[si]));
        si++;
      end
    end
    finish_run();
  end
endmodule